// File: doc/BRIEF.md
# SD Card Clock Divider Controller

This block produces the SD card clock from a 150 MHz base clock. Software programs it through a single 16-bit control register on a simple write-strobe bus, and the register can be read back combinationally. The register holds a divider code, an internal-clock enable, a read-only settled flag and a card-clock enable.

The supported divide ratios are not a standard set. Ratios 1, 2, 3 and 4 are linear steps, and above 4 the ratios are powers of two up to 256. The divider code is half the ratio, except for ratio 3, which has its own code. A code that is not legal selects the next slower legal ratio.

The intended bring-up order has three steps:
1. Program the code with the internal enable set.
2. Poll until the settled flag reads 1.
3. Set the card enable.

Writing zero stops everything. A change of ratio or card enable is applied only at the end of a divided period, so the card never sees a shortened pulse.

Top module: `sd_clkdiv_ctrl`

## Requirements
- R1: After reset, the read data is 0x0000 and the card clock is low.
- R2: The register layout is as follows. Bits 15:8 hold the divider code, bit 0 is the internal enable and bit 2 is the card enable. Bit 1 is the settled flag, which is read-only, so writes to it are ignored. All other bits read 0.
- R3: The settled flag reads 1 starting 16 base cycles after the write edge that sets the internal enable, and not before. It reads 0 from the first cycle after a write clears the internal enable.
- R4: The legal codes map to ratios as follows: 0 gives 1, 1 gives 2, 2 gives 4, 3 gives 3, 4 gives 8, 8 gives 16, 16 gives 32, 32 gives 64, 64 gives 128 and 128 gives 256.
- R5: An illegal code selects the smallest power-of-two ratio (8 to 256) that is at least twice the code. Codes above 128 select 256.
- R6: For ratio N ≥ 2, the card clock has period N base cycles. It is high for N/2 cycles, except for ratio 3, where it is high for 1 cycle and low for 2. Each period starts high.
- R7: With ratio 1 and both enables set, the card clock follows the base clock: it is high while the base clock is high and low while it is low.
- R8: The card clock stays low unless both the internal enable and the card enable are set. Card enable alone gives no output.
- R9: A new ratio written while the card clock runs takes effect only after the current period completes. Every pulse is either a full old-ratio pulse or a full new-ratio pulse.
- R10: Writing 0x0000 stops the card clock within two base cycles and clears the register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 150 MHz base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 16 | Register write data |
| rd_data | output | 16 | Register read data |
| card_clk | output | 1 | SD card clock |

## Verification
The assertions take two things for granted:
- The internal enable is cleared for at least one cycle before it is set again, so the settling counter restarts from zero.
- The write strobe is a clean single-cycle pulse, sampled on the base clock.

The stimulus always reaches a new ratio by writing zero first, then the code with the internal enable set. It waits out the settling time before setting the card enable, and it issues writes only on the falling clock edge, a full cycle apart.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;
  localparam int CODE_W  = 8;
  localparam int RATIO_W = 9;
  localparam int MAX_LOG = 8;

  // Maps a divider code to its ratio; illegal codes round towards slower.
  function automatic logic [RATIO_W-1:0] code_to_ratio(input logic [CODE_W-1:0] code);
    logic [RATIO_W:0]   want;
    logic [RATIO_W-1:0] r;
    want = {1'b0, code, 1'b0};
    r    = RATIO_W'(1) << MAX_LOG;
    case (code)
      8'd0: r = RATIO_W'(1);
      8'd1: r = RATIO_W'(2);
      8'd2: r = RATIO_W'(4);
      8'd3: r = RATIO_W'(3);
      default: begin
        for (int k = MAX_LOG; k >= 3; k--) begin
          if (((RATIO_W+1)'(1) << k) >= want) r = RATIO_W'(1) << k;
        end
      end
    endcase
    return r;
  endfunction

  // Number of high base cycles in one divided period.
  function automatic logic [RATIO_W-1:0] high_len(input logic [RATIO_W-1:0] ratio);
    return (ratio == RATIO_W'(3)) ? RATIO_W'(1) : (ratio >> 1);
  endfunction
endpackage

// File: rtl/sdclk_ctrl_reg.sv
module sdclk_ctrl_reg
  import sdclk_pkg::*;
#(
  parameter int STABLE_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [15:0]       wr_data,
  output logic [CODE_W-1:0] code_o,
  output logic              int_en_o,
  output logic              card_en_o,
  output logic              stable_o,
  output logic [15:0]       rd_data_o
);
  localparam int SW = $clog2(STABLE_CYCLES + 1);
  localparam logic [SW-1:0] SETTLED = SW'(STABLE_CYCLES);

  logic [CODE_W-1:0] code_q, code_d;
  logic              int_en_q, int_en_d;
  logic              card_en_q, card_en_d;
  logic [SW-1:0]     settle_q, settle_d;

  always_comb begin
    code_d    = code_q;
    int_en_d  = int_en_q;
    card_en_d = card_en_q;
    if (wr_en) begin
      code_d    = wr_data[15:8];
      int_en_d  = wr_data[0];
      card_en_d = wr_data[2];
    end
    if (!int_en_q)              settle_d = '0;
    else if (settle_q != SETTLED) settle_d = settle_q + SW'(1);
    else                        settle_d = settle_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q    <= '0;
      int_en_q  <= 1'b0;
      card_en_q <= 1'b0;
      settle_q  <= '0;
    end else begin
      code_q    <= code_d;
      int_en_q  <= int_en_d;
      card_en_q <= card_en_d;
      settle_q  <= settle_d;
    end
  end

  assign stable_o  = int_en_q && (settle_q == SETTLED);
  assign code_o    = code_q;
  assign int_en_o  = int_en_q;
  assign card_en_o = card_en_q;
  assign rd_data_o = {code_q, 5'b0, card_en_q, stable_o, int_en_q};

  p_settle_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !int_en_q |=> !stable_o);
  p_settle_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (stable_o && !wr_en) |=> stable_o);
endmodule

// File: rtl/sdclk_divider.sv
module sdclk_divider
  import sdclk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_i,
  input  logic              card_en_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              div_clk_o,
  output logic              pass_req_o
);
  logic [RATIO_W-1:0] req_ratio;
  logic [RATIO_W-1:0] ratio_q, ratio_d;
  logic [RATIO_W-1:0] cnt_q, cnt_d;
  logic               act_card_q, act_card_d;
  logic               div_q, div_d;
  logic               boundary;

  assign req_ratio = code_to_ratio(code_i);
  assign boundary  = (cnt_q == ratio_q - RATIO_W'(1));

  always_comb begin
    ratio_d    = ratio_q;
    act_card_d = act_card_q;
    cnt_d      = cnt_q;
    if (!run_i) begin
      ratio_d    = req_ratio;
      act_card_d = 1'b0;
      cnt_d      = '0;
    end else if (boundary) begin
      ratio_d    = req_ratio;
      act_card_d = card_en_i;
      cnt_d      = '0;
    end else begin
      cnt_d      = cnt_q + RATIO_W'(1);
    end
    div_d = run_i && act_card_d && (ratio_d != RATIO_W'(1)) &&
            (cnt_d < high_len(ratio_d));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ratio_q    <= RATIO_W'(1);
      act_card_q <= 1'b0;
      cnt_q      <= '0;
      div_q      <= 1'b0;
    end else begin
      ratio_q    <= ratio_d;
      act_card_q <= act_card_d;
      cnt_q      <= cnt_d;
      div_q      <= div_d;
    end
  end

  assign div_clk_o  = div_q;
  assign pass_req_o = run_i && act_card_q && (ratio_q == RATIO_W'(1));

  p_legal_ratio_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(ratio_q) || (ratio_q == RATIO_W'(3)));
  p_count_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < ratio_q);
  p_switch_on_edge_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && $past(run_i) && (ratio_q != $past(ratio_q))) |-> (cnt_q == '0));
  p_period_starts_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && $past(run_i) && $rose(div_q)) |-> (cnt_q == '0));
endmodule

// File: rtl/sdclk_out_gate.sv
module sdclk_out_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic pass_req_i,
  input  logic div_clk_i,
  output logic card_clk_o
);
  logic pass_q;

  // Enable captured while the base clock is low, so the AND never clips a pulse.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) pass_q <= 1'b0;
    else        pass_q <= pass_req_i;
  end

  assign card_clk_o = (clk & pass_q) | div_clk_i;

  p_paths_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(pass_req_i && div_clk_i));
endmodule

// File: rtl/sd_clkdiv_ctrl.sv
module sd_clkdiv_ctrl
  import sdclk_pkg::*;
#(
  parameter int STABLE_CYCLES = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [15:0] wr_data,
  output logic [15:0] rd_data,
  output logic        card_clk
);
  logic [1:0]        rst_sync_q;
  logic              rst_s;
  logic [CODE_W-1:0] code_s;
  logic              int_en_s, card_en_s, stable_s;
  logic              div_clk_s, pass_req_s;

  // Reset asserts at once and releases on the clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s = rst_sync_q[1];

  sdclk_ctrl_reg #(.STABLE_CYCLES(STABLE_CYCLES)) u_reg (
    .clk       (clk),
    .rst_n     (rst_s),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .code_o    (code_s),
    .int_en_o  (int_en_s),
    .card_en_o (card_en_s),
    .stable_o  (stable_s),
    .rd_data_o (rd_data)
  );

  sdclk_divider u_div (
    .clk        (clk),
    .rst_n      (rst_s),
    .run_i      (int_en_s),
    .card_en_i  (card_en_s),
    .code_i     (code_s),
    .div_clk_o  (div_clk_s),
    .pass_req_o (pass_req_s)
  );

  sdclk_out_gate u_gate (
    .clk        (clk),
    .rst_n      (rst_s),
    .pass_req_i (pass_req_s),
    .div_clk_i  (div_clk_s),
    .card_clk_o (card_clk)
  );

  p_idle_when_off_r8: assert property (@(posedge clk) disable iff (!rst_s)
    (!int_en_s && $past(!int_en_s)) |-> (!div_clk_s && !pass_req_s));
  p_stable_needs_enable_r3: assert property (@(posedge clk) disable iff (!rst_s)
    stable_s |-> int_en_s);
endmodule

// File: tb/sd_clkdiv_ctrl_test.sv
module sd_clkdiv_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = 16'h0000;
  logic [15:0] rd_data;
  logic        card_clk;
  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  sd_clkdiv_ctrl uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .card_clk(card_clk)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0; wr_data = 16'h0000;
  endtask

  task automatic samp_hi(output logic v);
    @(posedge clk); #1; v = card_clk;
  endtask

  function automatic int exp_ratio(input int code);
    int p;
    if (code == 0) return 1;
    if (code == 3) return 3;
    p = 2;
    while (p < 2 * code && p < 256) p = p * 2;
    return p;
  endfunction

  function automatic int exp_high(input int r);
    return (r == 3) ? 1 : r / 2;
  endfunction

  task automatic start(input int code);
    wr(16'h0000);
    wr({code[7:0], 8'h01});
    repeat (17) @(negedge clk);
    wr({code[7:0], 8'h05});
  endtask

  task automatic check_code(input int code, input string req);
    int r, h, bad, n;
    logic v, pv;
    r = exp_ratio(code);
    h = exp_high(r);
    start(code);
    bad = 0;
    if (r == 1) begin
      repeat (4) @(negedge clk);
      for (int i = 0; i < 8; i++) begin
        @(posedge clk); #1; if (card_clk !== 1'b1) bad++;
        #2; if (card_clk !== 1'b0) bad++;
      end
      chk(bad == 0, req, $sformatf("code %0d passthrough mismatches", code), bad, 0);
    end else begin
      pv = 1'b1; n = 0;
      do begin samp_hi(v); if (v === 1'b1 && pv === 1'b1) pv = 1'b1; else if (v !== 1'b1) pv = 1'b0; n++; end
      while (!(v === 1'b1 && pv === 1'b0 && n > 1) && n < 700);
      for (int i = 0; i < 2 * r; i++) begin
        if (i > 0) samp_hi(v);
        if (v !== ((i % r) < h)) bad++;
      end
      chk(bad == 0 && n < 700, req,
          $sformatf("code %0d ratio %0d high %0d waveform mismatches", code, r, h), bad, 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic v;
    logic smp [48];
    int bad;
    int codes_legal [10] = '{0, 1, 2, 3, 4, 8, 16, 32, 64, 128};
    int codes_odd [8] = '{5, 7, 9, 15, 17, 65, 129, 255};

    // R1: reset state
    repeat (3) @(negedge clk);
    chk(rd_data == 16'h0000, "R1", "rd_data in reset", rd_data, 0);
    chk(card_clk == 1'b0, "R1", "card_clk in reset", card_clk, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(rd_data == 16'h0000, "R1", "rd_data after reset", rd_data, 0);

    // R2: layout, read-only settled bit, reserved bits
    wr(16'hA5FF);
    chk(rd_data == 16'hA505, "R2", "readback of 0xA5FF", rd_data, 16'hA505);
    wr(16'h0000);

    // R3: settling delay
    wr(16'h0201);
    bad = 0;
    for (int i = 0; i < 15; i++) begin
      @(negedge clk); if (rd_data[1] !== 1'b0) bad++;
    end
    chk(bad == 0, "R3", "settled flag early", bad, 0);
    @(negedge clk);
    chk(rd_data[1] === 1'b1, "R3", "settled flag at 16 cycles", rd_data[1], 1);
    wr(16'h0200);
    chk(rd_data[1] === 1'b0, "R3", "settled flag after disable", rd_data[1], 0);

    // R8: card enable alone
    wr(16'h0404);
    bad = 0;
    for (int i = 0; i < 20; i++) begin
      @(posedge clk); #1; if (card_clk !== 1'b0) bad++;
      #2; if (card_clk !== 1'b0) bad++;
    end
    chk(bad == 0, "R8", "card clock with only card enable", bad, 0);
    chk(rd_data == 16'h0404, "R8", "readback card-only", rd_data, 16'h0404);

    // R4, R6, R7: legal codes
    foreach (codes_legal[k])
      check_code(codes_legal[k], codes_legal[k] == 0 ? "R7" : "R4/R6");
    // R5: illegal codes round to slower ratio
    foreach (codes_odd[k]) check_code(codes_odd[k], "R5");

    // R9: ratio change applied at period end
    start(4);
    v = 1'b1;
    while (v !== 1'b0) samp_hi(v);
    while (v !== 1'b1) samp_hi(v);
    fork
      begin repeat (2) @(negedge clk); wr(16'h0205); end
      begin
        smp[0] = v;
        for (int i = 1; i < 48; i++) samp_hi(smp[i]);
      end
    join
    bad = 0;
    for (int i = 0; i < 48; i++) begin
      logic e;
      e = (i < 8) ? (i < 4) : (((i - 8) % 4) < 2);
      if (smp[i] !== e) bad++;
    end
    chk(bad == 0, "R9", "ratio switch 8 to 4 waveform mismatches", bad, 0);

    // R10: writing zero stops output
    wr(16'h0000);
    chk(rd_data == 16'h0000, "R10", "register after zero write", rd_data, 0);
    @(negedge clk);
    bad = 0;
    for (int i = 0; i < 20; i++) begin
      @(posedge clk); #1; if (card_clk !== 1'b0) bad++;
      #2; if (card_clk !== 1'b0) bad++;
    end
    chk(bad == 0, "R10", "card clock after stop", bad, 0);

    // R10 with passthrough ratio
    start(0);
    repeat (4) @(negedge clk);
    wr(16'h0000);
    @(negedge clk);
    bad = 0;
    for (int i = 0; i < 10; i++) begin
      @(posedge clk); #1; if (card_clk !== 1'b0) bad++;
    end
    chk(bad == 0, "R10", "passthrough stopped", bad, 0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule